// File: doc/BRIEF.md
# Vector Widening Unpack Unit

This block widens half of a 128-bit vector operand into a full 128-bit result. A caller presents one source vector and an 11-bit operation code with a valid strobe. The unit selects either the most significant or the least significant 64 bits of the source. It then doubles the width of every element in that half, so that the widened elements fill the whole result.

Three element formats are handled. Signed bytes become signed halfwords. Signed halfwords become signed words. Packed 16-bit colour pixels, with a one-bit top field and three five-bit channels, become 32-bit words with one byte per channel. The one-bit field is replicated across the whole top byte, and each five-bit channel sits at the bottom of its byte with zeros above it. The result is registered and appears one cycle after the request. An unrecognised code raises an illegal flag and leaves the held result unchanged.

Top module: `vec_unpack_unit`

## Requirements
- R1: Code 0x20E widens the eight bytes of bits [127:64] to halfwords, and code 0x28E does the same for bits [63:0]. Each output halfword is the sign-extended byte.
- R2: Code 0x24E widens the four halfwords of bits [127:64] to words, and code 0x2CE does the same for bits [63:0]. Each output word is the sign-extended halfword.
- R3: In both signed formats the added upper part of an element is all ones when the source element is negative (top bit 1) and all zeros otherwise.
- R4: Code 0x34E expands the four 16-bit pixels of bits [127:64], and code 0x3CE expands those of bits [63:0]. A pixel p becomes {8{p[15]}, 3'b000, p[14:10], 3'b000, p[9:5], 3'b000, p[4:0]}.
- R5: Operation code bit 7 selects the half, where 0 means bits [127:64] and 1 means bits [63:0]. Element order is preserved: the most significant element of the chosen half lands in the most significant result lane, and so on downwards.
- R6: out_valid is high in exactly the cycle after a cycle with in_valid high, and low otherwise.
- R7: Any code other than the six listed above is illegal. In the following cycle out_valid and out_illegal are both high, and out_result keeps its previous value.
- R8: While rst is high (synchronous, active high), out_valid, out_illegal and out_result are all driven to zero on each clock edge.
- R9: out_result changes only after a legal request. Cycles without in_valid leave it unchanged whatever in_op and in_b carry, and out_illegal stays low in the cycle after such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 11 | Operation code |
| in_b | input | 128 | Source vector |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | 128 | Registered widened vector |
| out_illegal | output | 1 | Unsupported code seen in the previous cycle |

## Verification
The assertions take only two things for granted about the inputs. in_valid must be a clean 0 or 1 at every clock edge once reset is released. Reset must be held for at least one edge before the first request. The bench drives every input on the falling edge from a single initial block, so each input is stable around the rising edge. The stimulus covers all six legal codes and illegal codes that differ from legal ones by a single bit. It also includes idle cycles with garbage on in_op and in_b, so the hold and illegal properties are reached as well as the widening paths.

// File: rtl/vupk_pkg.sv
package vupk_pkg;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_BYTE = 2'd1,
    K_HALF = 2'd2,
    K_PIX  = 2'd3
  } vupk_kind_e;

  // Bit 7 of each code picks the low half of the source.
  localparam logic [10:0] OP_BYTE_HI = 11'h20E;
  localparam logic [10:0] OP_BYTE_LO = 11'h28E;
  localparam logic [10:0] OP_HALF_HI = 11'h24E;
  localparam logic [10:0] OP_HALF_LO = 11'h2CE;
  localparam logic [10:0] OP_PIX_HI  = 11'h34E;
  localparam logic [10:0] OP_PIX_LO  = 11'h3CE;
  localparam int          HALF_SEL_BIT = 7;

  function automatic logic [15:0] sext_8_16(input logic [7:0] v);
    return {{8{v[7]}}, v};
  endfunction

  function automatic logic [31:0] sext_16_32(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  // 1:5:5:5 pixel to 8:8:8:8 word; the one-bit field fills its byte.
  function automatic logic [31:0] pix_16_32(input logic [15:0] p);
    return {{8{p[15]}}, 3'b000, p[14:10], 3'b000, p[9:5], 3'b000, p[4:0]};
  endfunction

endpackage

// File: rtl/vupk_decode.sv
module vupk_decode
  import vupk_pkg::*;
#(
  parameter int OPW = 11
) (
  input  logic [OPW-1:0] op,
  output vupk_kind_e     kind,
  output logic           take_low,
  output logic           legal
);

  always_comb begin
    kind = K_NONE;
    unique case (op)
      OP_BYTE_HI, OP_BYTE_LO: kind = K_BYTE;
      OP_HALF_HI, OP_HALF_LO: kind = K_HALF;
      OP_PIX_HI,  OP_PIX_LO:  kind = K_PIX;
      default:                kind = K_NONE;
    endcase
  end

  assign legal    = (kind != K_NONE);
  assign take_low = op[HALF_SEL_BIT];

endmodule

// File: rtl/vupk_widen.sv
module vupk_widen
  import vupk_pkg::*;
#(
  parameter int HALF_W = 64
) (
  input  logic [HALF_W-1:0]   half,
  input  vupk_kind_e          kind,
  output logic [2*HALF_W-1:0] wide
);

  localparam int N_BYTES = HALF_W / 8;
  localparam int N_HALFS = HALF_W / 16;

  logic [2*HALF_W-1:0] byte_wide;
  logic [2*HALF_W-1:0] half_wide;
  logic [2*HALF_W-1:0] pix_wide;

  // Lane g of the output takes element g of the half, so order is kept.
  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    assign byte_wide[16*g +: 16] = sext_8_16(half[8*g +: 8]);
  end

  for (genvar g = 0; g < N_HALFS; g++) begin : g_half
    assign half_wide[32*g +: 32] = sext_16_32(half[16*g +: 16]);
    assign pix_wide[32*g +: 32]  = pix_16_32(half[16*g +: 16]);
  end

  always_comb begin
    unique case (kind)
      K_BYTE:  wide = byte_wide;
      K_HALF:  wide = half_wide;
      K_PIX:   wide = pix_wide;
      default: wide = '0;
    endcase
  end

endmodule

// File: rtl/vec_unpack_unit.sv
module vec_unpack_unit
  import vupk_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int OPW   = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OPW-1:0]   in_op,
  input  logic [VEC_W-1:0] in_b,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_result,
  output logic             out_illegal
);

  localparam int HALF_W  = VEC_W / 2;
  localparam int N_HW    = VEC_W / 16;
  localparam int N_WORDS = VEC_W / 32;

  vupk_kind_e          dec_kind;
  logic                dec_low;
  logic                dec_legal;
  logic [HALF_W-1:0]   src_half;
  logic [VEC_W-1:0]    widened;
  logic                load_result;
  vupk_kind_e          kind_q;

  vupk_decode #(.OPW(OPW)) u_decode (
    .op       (in_op),
    .kind     (dec_kind),
    .take_low (dec_low),
    .legal    (dec_legal)
  );

  assign src_half = dec_low ? in_b[HALF_W-1:0] : in_b[VEC_W-1:HALF_W];

  vupk_widen #(.HALF_W(HALF_W)) u_widen (
    .half (src_half),
    .kind (dec_kind),
    .wide (widened)
  );

  assign load_result = in_valid && dec_legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
      kind_q      <= K_NONE;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid && !dec_legal;
      if (load_result) begin
        out_result <= widened;
        kind_q     <= dec_kind;
      end
    end
  end

  // Named observation wires for the assertions below.
  logic [N_HW-1:0]    byte_fill_bad;
  logic [N_WORDS-1:0] half_fill_bad;
  logic [N_WORDS-1:0] pix_pad_bad;

  for (genvar g = 0; g < N_HW; g++) begin : g_chk_b
    assign byte_fill_bad[g] =
      out_result[16*g+8 +: 8] != (out_result[16*g+7] ? 8'hFF : 8'h00);
  end
  for (genvar g = 0; g < N_WORDS; g++) begin : g_chk_w
    assign half_fill_bad[g] =
      out_result[32*g+16 +: 16] != (out_result[32*g+15] ? 16'hFFFF : 16'h0000);
    assign pix_pad_bad[g] =
      (out_result[32*g+5 +: 3] != 3'b000) ||
      (out_result[32*g+13 +: 3] != 3'b000) ||
      (out_result[32*g+21 +: 3] != 3'b000);
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R6
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_illegal)); // R6
  AST_ILLEGAL_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> out_valid); // R7
  AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> $stable(out_result)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_result)); // R9
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_illegal && out_result == '0)); // R8
  AST_SIGN_FILL_BYTE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_illegal && kind_q == K_BYTE) |-> (byte_fill_bad == '0)); // R3
  AST_SIGN_FILL_HALF: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_illegal && kind_q == K_HALF) |-> (half_fill_bad == '0)); // R3
  AST_PIX_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_illegal && kind_q == K_PIX) |-> (pix_pad_bad == '0)); // R4

endmodule

// File: tb/tb_vec_unpack_unit.sv
module tb_vec_unpack_unit;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [10:0]  in_op;
  logic [127:0] in_b;
  logic         out_valid;
  logic [127:0] out_result;
  logic         out_illegal;

  int n_cmp  = 0;
  int n_bad  = 0;
  int cycles = 0;
  bit done   = 0;

  logic         exp_valid;
  logic         exp_ill;
  logic [127:0] exp_res;

  always #10 clk = ~clk;

  vec_unpack_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_b(in_b),
    .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
  );

  function automatic bit is_legal(input logic [10:0] op);
    return op inside {11'h20E, 11'h28E, 11'h24E, 11'h2CE, 11'h34E, 11'h3CE};
  endfunction

  function automatic string tag_of(input logic [10:0] op);
    if (!is_legal(op)) return "R7";
    if (op == 11'h20E || op == 11'h28E) return "R1";
    if (op == 11'h24E || op == 11'h2CE) return "R2";
    return "R4";
  endfunction

  // Behavioural model: walk elements from the most significant down.
  function automatic logic [127:0] model(input logic [10:0] op, input logic [127:0] b);
    logic [63:0]  h;
    logic [127:0] r;
    r = '0;
    h = (op == 11'h28E || op == 11'h2CE || op == 11'h3CE) ? b[63:0] : b[127:64];
    if (op == 11'h20E || op == 11'h28E) begin
      for (int k = 0; k < 8; k++) begin
        int e;
        e = int'(h[63-8*k -: 8]);
        if (e >= 128) e = e - 256;
        r[127-16*k -: 16] = 16'(e);
      end
    end else if (op == 11'h24E || op == 11'h2CE) begin
      for (int k = 0; k < 4; k++) begin
        longint e;
        e = longint'(h[63-16*k -: 16]);
        if (e >= 32768) e = e - 65536;
        r[127-32*k -: 32] = 32'(e);
      end
    end else begin
      for (int k = 0; k < 4; k++) begin
        int p;
        int w;
        p = int'(h[63-16*k -: 16]);
        w = ((p / 1024) % 32) * 65536 + ((p / 32) % 32) * 256 + (p % 32);
        if (p >= 32768) w = w + 32'hFF000000;
        r[127-32*k -: 32] = 32'(w);
      end
    end
    return r;
  endfunction

  task automatic compare(input string tag);
    n_cmp++;
    if (out_valid !== exp_valid || out_illegal !== exp_ill || out_result !== exp_res) begin
      n_bad++;
      $display("FAIL %s: valid=%0b illegal=%0b result=%h expected valid=%0b illegal=%0b result=%h",
               tag, out_valid, out_illegal, out_result, exp_valid, exp_ill, exp_res);
    end
  endtask

  // Called on a falling edge; compares on the next falling edge.
  task automatic step(input bit v, input logic [10:0] op, input logic [127:0] b,
                      input string tag);
    in_valid = v;
    in_op    = op;
    in_b     = b;
    exp_valid = v;
    exp_ill   = v && !is_legal(op);
    if (v && is_legal(op)) exp_res = model(op, b);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
      finish_run();
    end
  end

  localparam logic [127:0] ORDERED = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
  localparam logic [127:0] SIGNS   = 128'h807F_00FF_017E_81C0_7F80_FF00_40BF_02FE;
  localparam logic [127:0] PIXELS  = 128'hFFFF_8000_7FFF_0001_0421_7C00_03E0_801F;

  initial begin
    logic [10:0] ops[6];
    ops = '{11'h20E, 11'h28E, 11'h24E, 11'h2CE, 11'h34E, 11'h3CE};
    rst = 1'b1; in_valid = 1'b0; in_op = '0; in_b = '0;
    exp_valid = 0; exp_ill = 0; exp_res = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R8");                               // reset state
    rst = 1'b0;

    step(1, 11'h20E, ORDERED, "R1");
    step(1, 11'h28E, ORDERED, "R1");
    step(1, 11'h24E, ORDERED, "R2");
    step(1, 11'h2CE, ORDERED, "R2");
    step(1, 11'h20E, SIGNS, "R3");
    step(1, 11'h28E, SIGNS, "R3");
    step(1, 11'h24E, SIGNS, "R3");
    step(1, 11'h2CE, SIGNS, "R3");
    step(1, 11'h34E, PIXELS, "R4");
    step(1, 11'h3CE, PIXELS, "R4");
    step(1, 11'h34E, ORDERED, "R5");
    step(1, 11'h3CE, ORDERED, "R5");
    step(0, 11'h20E, SIGNS, "R6");
    step(1, 11'h24E, PIXELS, "R6");
    step(0, 11'h7FF, '1, "R9");
    step(0, 11'h000, ORDERED, "R9");
    step(1, 11'h000, SIGNS, "R7");
    step(1, 11'h20F, SIGNS, "R7");
    step(1, 11'h30E, SIGNS, "R7");
    step(1, 11'h60E, SIGNS, "R7");
    step(1, 11'h3CF, PIXELS, "R7");
    step(1, 11'h3CE, PIXELS, "R4");

    for (int i = 0; i < 600; i++) begin
      logic [10:0]  op;
      logic [127:0] b;
      bit           v;
      b  = {$urandom, $urandom, $urandom, $urandom};
      v  = ($urandom % 5) != 0;
      op = (($urandom % 6) == 0) ? 11'($urandom) : ops[$urandom % 6];
      step(v, op, b, v ? tag_of(op) : "R9");
    end

    rst = 1'b1;
    exp_valid = 0; exp_ill = 0; exp_res = '0;
    @(posedge clk);
    @(negedge clk);
    compare("R8");
    finish_run();
  end

endmodule